// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits on the device side of a parallel NOR flash bus and turns host bus writes into operations. Each write is taken on the rising edge of the write strobe, after the strobe has been brought into the clock domain, and only while the chip select is high. Multi-cycle command sequences open with two unlock writes and are matched against exact address and data pairs. The unlock addresses depend on whether the bus is in byte or word mode. Any write that breaks a sequence drops the decoder back to array reading.

Decoded commands become one-cycle start pulses for a program/erase engine. In this block a set of down counters stands in for that engine and models program time, erase time and the window in which sectors are gathered. The block keeps a bitmap of the sectors selected for erase. It handles erase suspend and resume, and it presents a read-mode code that tells the read path whether to return array data, identification data or operation status.

Top module: `nfc_cmd_decoder`

## Requirements
- R1: Commands are taken from data bits 7:0. In word mode the first unlock write is AAh at an address whose bits 10:0 are 555h, and the second is 55h at bits 10:0 = 2AAh. In byte mode the same data are compared against address bits 11:0, at AAAh and 555h. An unlock write at the address for the other mode is an invalid cycle.
- R2: Unlock, then A0h at the first unlock address, then one more write, gives a single `prog_start_o` pulse. The pulse carries that write's full address and data. `busy_o` goes high and the read mode becomes status (code 2). Once PROG_CYCLES have elapsed, `busy_o` falls and the read mode becomes array (code 0).
- R3: Unlock, 80h, unlock, then 10h at the first unlock address gives one `chip_erase_start_o` pulse, with every bit of `sector_map_o` set.
- R4: The same five-cycle prefix followed by 30h at any address opens a gathering window with no start pulse yet. The sector index is address bits 18:12 in word mode and bits 19:13 in byte mode. Each further 30h write during the window adds its sector and restarts the WINDOW_CYCLES count. When the window closes, one `sector_erase_start_o` pulse is issued.
- R5: A write other than 30h inside the window abandons the pending erase. `sector_map_o` is cleared, no erase pulse follows, and the mode returns to array. Whenever neither busy nor suspended, the map is zero.
- R6: F0h at any address, with no operation running, returns the read mode to array and restarts sequence matching.
- R7: A wrong data value, a wrong address or an out-of-order cycle at any step gives no pulse. It returns the mode to array and restarts matching, so for example A0h with no unlock has no effect.
- R8: While a program operation runs, every write is ignored: the mode stays status and no partial sequence is kept. Outside of an erase pause, `busy_o` is high exactly when the mode is status.
- R9: During an erase, B0h at any address gives a `suspend_o` pulse. `suspended_o` goes high, `busy_o` goes low, the mode becomes array and the erase count freezes. While suspended, 30h as the first cycle of a sequence gives a `resume_o` pulse, and the erase continues with its remaining count in status mode.
- R10: While suspended, a program to a sector outside the map runs normally and the block stays suspended afterwards. A program to a sector inside the map is rejected. The 80h erase prefix is treated as invalid.
- R11: B0h and 30h written while no erase is running or suspended are invalid cycles. They give no pulse.
- R12: Unlock, then 90h at the first unlock address, selects identification mode (code 1). Code 3 never occurs.
- R13: Writes made with `cs_i` low have no effect.
- R14: `rst_ni` low aborts any operation at once. It clears the map and the busy and suspended flags and sets array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also the hardware abort |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | Write strobe, asynchronous, write on rising edge |
| byte_mode_i | input | 1 | 1 = byte bus, 0 = word bus |
| addr_i | input | WORD_AW+1 (20) | Bus address; bit 0 is the byte lane in byte mode |
| data_i | input | DATA_W (16) | Bus write data |
| prog_start_o | output | 1 | Program start pulse |
| prog_addr_o | output | WORD_AW+1 (20) | Captured program address |
| prog_data_o | output | DATA_W (16) | Captured program data |
| chip_erase_start_o | output | 1 | Chip erase start pulse |
| sector_erase_start_o | output | 1 | Sector erase start pulse |
| sector_map_o | output | 2**(WORD_AW-SECT_LSB) (128) | Sectors selected for erase |
| suspend_o | output | 1 | Erase suspended pulse |
| resume_o | output | 1 | Erase resumed pulse |
| busy_o | output | 1 | Program, window or erase is running |
| suspended_o | output | 1 | Erase is paused |
| read_mode_o | output | 2 | 0 array, 1 identification, 2 status |

## Verification
The checks assume that address and data are stable from before the strobe rises until the synchroniser has produced its edge. They also assume the strobe stays high and then low for at least SYNC_STAGES+1 clocks each, so that one host write gives exactly one event. The bench drives every write as a fixed eight-cycle frame that meets both conditions. It changes chip select and byte mode only between frames. Reset is asserted only on a clock-independent negative edge, and the assertions are disabled while it is held.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_ID     = 2'd1,
    RM_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UL1, SQ_UL2, SQ_PROG, SQ_ER1, SQ_ER2, SQ_ER3
  } seq_e;

  typedef enum logic [2:0] {
    EN_IDLE, EN_PROG, EN_WIN, EN_ERASE, EN_SUSP, EN_SPROG
  } eng_e;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic susp;
    logic resume;
    logic abort;
  } eng_req_t;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_RESUME  = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_ID      = 8'h90;

  localparam logic [10:0] WA_FIRST  = 11'h555;
  localparam logic [10:0] WA_SECOND = 11'h2AA;
  localparam logic [11:0] BA_FIRST  = 12'hAAA;
  localparam logic [11:0] BA_SECOND = 12'h555;

endpackage

// File: rtl/nfc_strobe_sync.sv
module nfc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/nfc_addr_decode.sv
module nfc_addr_decode import nfc_pkg::*; #(
  parameter int WORD_AW  = 19,
  parameter int SECT_LSB = 12,
  parameter int SECT_W   = WORD_AW - SECT_LSB
) (
  input  logic [WORD_AW:0]   addr_i,
  input  logic               byte_mode_i,
  output logic               at_a1_o,
  output logic               at_a2_o,
  output logic [SECT_W-1:0]  sect_idx_o
);
  // byte mode shifts the word address up by the lane bit
  always_comb begin
    if (byte_mode_i) begin
      at_a1_o    = (addr_i[11:0] == BA_FIRST);
      at_a2_o    = (addr_i[11:0] == BA_SECOND);
      sect_idx_o = addr_i[WORD_AW:SECT_LSB+1];
    end else begin
      at_a1_o    = (addr_i[10:0] == WA_FIRST);
      at_a2_o    = (addr_i[10:0] == WA_SECOND);
      sect_idx_o = addr_i[WORD_AW-1:SECT_LSB];
    end
  end
endmodule

// File: rtl/nfc_seq_fsm.sv
module nfc_seq_fsm import nfc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] cmd_i,
  input  logic       at_a1_i,
  input  logic       at_a2_i,
  input  logic       sect_hit_i,
  input  logic       prog_busy_i,
  input  logic       win_i,
  input  logic       erasing_i,
  input  logic       susp_i,
  input  logic       done_i,
  output eng_req_t   req_o,
  output rd_mode_e   mode_o
);
  seq_e     seq_q, seq_n;
  rd_mode_e mode_q, mode_n;
  logic     bad;

  always_comb begin
    req_o  = '0;
    seq_n  = seq_q;
    mode_n = mode_q;
    bad    = 1'b0;
    if (done_i) mode_n = RM_ARRAY;
    if (wr_i && !prog_busy_i) begin
      if (win_i) begin
        if (cmd_i == CMD_SECTOR) req_o.sect = 1'b1;
        else begin
          req_o.abort = 1'b1;
          bad = 1'b1;
        end
      end else if (erasing_i) begin
        if (cmd_i == CMD_SUSPEND) begin
          req_o.susp = 1'b1;
          mode_n = RM_ARRAY;
        end
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            if (cmd_i == CMD_UNLOCK1 && at_a1_i) seq_n = SQ_UL1;
            else if (susp_i && cmd_i == CMD_RESUME) begin
              req_o.resume = 1'b1;
              mode_n = RM_STATUS;
            end else bad = 1'b1;
          end
          SQ_UL1: begin
            if (cmd_i == CMD_UNLOCK2 && at_a2_i) seq_n = SQ_UL2;
            else bad = 1'b1;
          end
          SQ_UL2: begin
            if (!at_a1_i) bad = 1'b1;
            else if (cmd_i == CMD_PROG) seq_n = SQ_PROG;
            else if (cmd_i == CMD_ERASE && !susp_i) seq_n = SQ_ER1;
            else if (cmd_i == CMD_ID) begin
              seq_n  = SQ_IDLE;
              mode_n = RM_ID;
            end else bad = 1'b1;
          end
          SQ_PROG: begin
            // programming the sector under erase is refused while paused
            if (susp_i && sect_hit_i) bad = 1'b1;
            else begin
              req_o.prog = 1'b1;
              seq_n  = SQ_IDLE;
              mode_n = RM_STATUS;
            end
          end
          SQ_ER1: begin
            if (cmd_i == CMD_UNLOCK1 && at_a1_i) seq_n = SQ_ER2;
            else bad = 1'b1;
          end
          SQ_ER2: begin
            if (cmd_i == CMD_UNLOCK2 && at_a2_i) seq_n = SQ_ER3;
            else bad = 1'b1;
          end
          SQ_ER3: begin
            seq_n = SQ_IDLE;
            if (cmd_i == CMD_CHIP && at_a1_i) begin
              req_o.chip = 1'b1;
              mode_n = RM_STATUS;
            end else if (cmd_i == CMD_SECTOR) begin
              req_o.sect = 1'b1;
              mode_n = RM_STATUS;
            end else bad = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      if (bad) begin
        seq_n  = SQ_IDLE;
        mode_n = RM_ARRAY;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SQ_IDLE;
      mode_q <= RM_ARRAY;
    end else begin
      seq_q  <= seq_n;
      mode_q <= mode_n;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/nfc_op_engine.sv
module nfc_op_engine import nfc_pkg::*; #(
  parameter int AW            = 20,
  parameter int DATA_W        = 16,
  parameter int SECT_W        = 7,
  parameter int NUM_SECT      = 128,
  parameter int PROG_CYCLES   = 40,
  parameter int ERASE_CYCLES  = 120,
  parameter int WINDOW_CYCLES = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  eng_req_t            req_i,
  input  logic [SECT_W-1:0]   sect_idx_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                prog_busy_o,
  output logic                win_o,
  output logic                erasing_o,
  output logic                susp_o,
  output logic                done_o,
  output logic                busy_o,
  output logic                suspended_o,
  output logic                prog_start_o,
  output logic [AW-1:0]       prog_addr_o,
  output logic [DATA_W-1:0]   prog_data_o,
  output logic                chip_start_o,
  output logic                sect_start_o,
  output logic                susp_pulse_o,
  output logic                resume_pulse_o,
  output logic [NUM_SECT-1:0] map_o
);
  localparam int MAX_A = (PROG_CYCLES > WINDOW_CYCLES) ? PROG_CYCLES : WINDOW_CYCLES;
  localparam int MAXC  = (MAX_A > ERASE_CYCLES) ? MAX_A : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  eng_e               st_q;
  logic [CNT_W-1:0]   pcnt_q, ecnt_q;
  logic [NUM_SECT-1:0] sect_bit;

  assign sect_bit = NUM_SECT'(1) << sect_idx_i;

  assign prog_busy_o = (st_q == EN_PROG) || (st_q == EN_SPROG);
  assign win_o       = (st_q == EN_WIN);
  assign erasing_o   = (st_q == EN_ERASE);
  assign susp_o      = (st_q == EN_SUSP);
  assign busy_o      = prog_busy_o || win_o || erasing_o;
  assign suspended_o = (st_q == EN_SUSP) || (st_q == EN_SPROG);
  assign done_o      = (prog_busy_o && pcnt_q == '0) || (erasing_o && ecnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= EN_IDLE;
      pcnt_q         <= '0;
      ecnt_q         <= '0;
      map_o          <= '0;
      prog_addr_o    <= '0;
      prog_data_o    <= '0;
      prog_start_o   <= 1'b0;
      chip_start_o   <= 1'b0;
      sect_start_o   <= 1'b0;
      susp_pulse_o   <= 1'b0;
      resume_pulse_o <= 1'b0;
    end else begin
      prog_start_o   <= 1'b0;
      chip_start_o   <= 1'b0;
      sect_start_o   <= 1'b0;
      susp_pulse_o   <= 1'b0;
      resume_pulse_o <= 1'b0;
      case (st_q)
        EN_IDLE: begin
          if (req_i.prog) begin
            st_q         <= EN_PROG;
            pcnt_q       <= CNT_W'(PROG_CYCLES - 1);
            prog_start_o <= 1'b1;
            prog_addr_o  <= addr_i;
            prog_data_o  <= data_i;
          end else if (req_i.chip) begin
            st_q         <= EN_ERASE;
            ecnt_q       <= CNT_W'(ERASE_CYCLES - 1);
            map_o        <= '1;
            chip_start_o <= 1'b1;
          end else if (req_i.sect) begin
            st_q   <= EN_WIN;
            pcnt_q <= CNT_W'(WINDOW_CYCLES - 1);
            map_o  <= sect_bit;
          end
        end
        EN_PROG: begin
          if (pcnt_q == '0) st_q <= EN_IDLE;
          else pcnt_q <= pcnt_q - 1'b1;
        end
        EN_WIN: begin
          if (req_i.abort) begin
            st_q  <= EN_IDLE;
            map_o <= '0;
          end else if (req_i.sect) begin
            map_o  <= map_o | sect_bit;
            pcnt_q <= CNT_W'(WINDOW_CYCLES - 1);
          end else if (pcnt_q == '0) begin
            st_q         <= EN_ERASE;
            ecnt_q       <= CNT_W'(ERASE_CYCLES - 1);
            sect_start_o <= 1'b1;
          end else pcnt_q <= pcnt_q - 1'b1;
        end
        EN_ERASE: begin
          if (ecnt_q == '0) begin
            st_q  <= EN_IDLE;
            map_o <= '0;
          end else if (req_i.susp) begin
            st_q         <= EN_SUSP;
            susp_pulse_o <= 1'b1;
          end else ecnt_q <= ecnt_q - 1'b1;
        end
        EN_SUSP: begin
          if (req_i.resume) begin
            st_q           <= EN_ERASE;
            resume_pulse_o <= 1'b1;
          end else if (req_i.prog) begin
            st_q         <= EN_SPROG;
            pcnt_q       <= CNT_W'(PROG_CYCLES - 1);
            prog_start_o <= 1'b1;
            prog_addr_o  <= addr_i;
            prog_data_o  <= data_i;
          end
        end
        EN_SPROG: begin
          if (pcnt_q == '0) st_q <= EN_SUSP;
          else pcnt_q <= pcnt_q - 1'b1;
        end
        default: st_q <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nfc_cmd_decoder.sv
module nfc_cmd_decoder import nfc_pkg::*; #(
  parameter int WORD_AW       = 19,
  parameter int SECT_LSB      = 12,
  parameter int DATA_W        = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int PROG_CYCLES   = 40,
  parameter int ERASE_CYCLES  = 120,
  parameter int WINDOW_CYCLES = 30
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 cs_i,
  input  logic                                 we_i,
  input  logic                                 byte_mode_i,
  input  logic [WORD_AW:0]                     addr_i,
  input  logic [DATA_W-1:0]                    data_i,
  output logic                                 prog_start_o,
  output logic [WORD_AW:0]                     prog_addr_o,
  output logic [DATA_W-1:0]                    prog_data_o,
  output logic                                 chip_erase_start_o,
  output logic                                 sector_erase_start_o,
  output logic [(1<<(WORD_AW-SECT_LSB))-1:0]   sector_map_o,
  output logic                                 suspend_o,
  output logic                                 resume_o,
  output logic                                 busy_o,
  output logic                                 suspended_o,
  output logic [1:0]                           read_mode_o
);
  localparam int AW       = WORD_AW + 1;
  localparam int SECT_W   = WORD_AW - SECT_LSB;
  localparam int NUM_SECT = 1 << SECT_W;

  logic              we_rise, wr_ev;
  logic              at_a1, at_a2, sect_hit;
  logic [SECT_W-1:0] sect_idx;
  logic              prog_busy, win, erasing, susp, done;
  eng_req_t          req;
  rd_mode_e          mode;

  nfc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (we_i),
    .rise_o   (we_rise)
  );

  assign wr_ev = we_rise & cs_i;

  nfc_addr_decode #(.WORD_AW(WORD_AW), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W)) u_adec (
    .addr_i      (addr_i),
    .byte_mode_i (byte_mode_i),
    .at_a1_o     (at_a1),
    .at_a2_o     (at_a2),
    .sect_idx_o  (sect_idx)
  );

  assign sect_hit = sector_map_o[sect_idx];

  nfc_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_ev),
    .cmd_i       (data_i[7:0]),
    .at_a1_i     (at_a1),
    .at_a2_i     (at_a2),
    .sect_hit_i  (sect_hit),
    .prog_busy_i (prog_busy),
    .win_i       (win),
    .erasing_i   (erasing),
    .susp_i      (susp),
    .done_i      (done),
    .req_o       (req),
    .mode_o      (mode)
  );

  nfc_op_engine #(
    .AW(AW), .DATA_W(DATA_W), .SECT_W(SECT_W), .NUM_SECT(NUM_SECT),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_eng (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req),
    .sect_idx_i     (sect_idx),
    .addr_i         (addr_i),
    .data_i         (data_i),
    .prog_busy_o    (prog_busy),
    .win_o          (win),
    .erasing_o      (erasing),
    .susp_o         (susp),
    .done_o         (done),
    .busy_o         (busy_o),
    .suspended_o    (suspended_o),
    .prog_start_o   (prog_start_o),
    .prog_addr_o    (prog_addr_o),
    .prog_data_o    (prog_data_o),
    .chip_start_o   (chip_erase_start_o),
    .sect_start_o   (sector_erase_start_o),
    .susp_pulse_o   (suspend_o),
    .resume_pulse_o (resume_o),
    .map_o          (sector_map_o)
  );

  assign read_mode_o = mode;
endmodule

// File: rtl/nfc_cmd_decoder_sva.sv
module nfc_cmd_decoder_sva #(
  parameter int NUM_SECT = 128
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                prog_start_o,
  input logic                chip_erase_start_o,
  input logic                sector_erase_start_o,
  input logic                suspend_o,
  input logic                resume_o,
  input logic                busy_o,
  input logic                suspended_o,
  input logic [1:0]          read_mode_o,
  input logic [NUM_SECT-1:0] sector_map_o
);
  p_pulse_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, chip_erase_start_o, sector_erase_start_o, suspend_o, resume_o}));

  p_prog_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> busy_o && read_mode_o == 2'd2);

  p_chip_map_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_start_o |-> &sector_map_o);

  p_sect_map_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_erase_start_o |-> busy_o && sector_map_o != '0);

  p_idle_map_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !suspended_o) |-> sector_map_o == '0);

  p_status_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (read_mode_o == 2'd2));

  p_suspend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> suspended_o && !busy_o && read_mode_o == 2'd0);

  p_resume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> busy_o && !suspended_o);

  p_map_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && $past(suspended_o)) |-> $stable(sector_map_o));

  p_id_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_mode_o == 2'd1 |-> !busy_o);

  p_mode_legal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_mode_o != 2'd3);
endmodule

bind nfc_cmd_decoder nfc_cmd_decoder_sva #(.NUM_SECT(NUM_SECT)) u_sva (
  .clk_i                (clk_i),
  .rst_ni               (rst_ni),
  .prog_start_o         (prog_start_o),
  .chip_erase_start_o   (chip_erase_start_o),
  .sector_erase_start_o (sector_erase_start_o),
  .suspend_o            (suspend_o),
  .resume_o             (resume_o),
  .busy_o               (busy_o),
  .suspended_o          (suspended_o),
  .read_mode_o          (read_mode_o),
  .sector_map_o         (sector_map_o)
);

// File: tb/nfc_cmd_decoder_bench.sv
`timescale 1ns/1ps
module nfc_cmd_decoder_bench;
  localparam int PROG_T  = 40;
  localparam int ERASE_T = 120;
  localparam int WIN_T   = 30;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs = 1'b1;
  logic         we = 1'b0;
  logic         bmode = 1'b0;
  logic [19:0]  addr = '0;
  logic [15:0]  data = '0;
  logic         prog_start, chip_start, sect_start, susp_p, res_p, busy, susp;
  logic [19:0]  prog_addr;
  logic [15:0]  prog_data;
  logic [127:0] map;
  logic [1:0]   mode;

  int n_chk = 0, n_fail = 0;
  int n_prog = 0, n_chip = 0, n_sect = 0, n_susp = 0, n_res = 0;
  logic [19:0] last_pa = '0;
  logic [15:0] last_pd = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nfc_cmd_decoder #(
    .PROG_CYCLES(PROG_T), .ERASE_CYCLES(ERASE_T), .WINDOW_CYCLES(WIN_T)
  ) u_nfc_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .byte_mode_i(bmode),
    .addr_i(addr), .data_i(data),
    .prog_start_o(prog_start), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .chip_erase_start_o(chip_start), .sector_erase_start_o(sect_start),
    .sector_map_o(map), .suspend_o(susp_p), .resume_o(res_p),
    .busy_o(busy), .suspended_o(susp), .read_mode_o(mode)
  );

  always @(negedge clk) begin
    if (prog_start) begin n_prog++; last_pa = prog_addr; last_pd = prog_data; end
    if (chip_start) n_chip++;
    if (sect_start) n_sect++;
    if (susp_p) n_susp++;
    if (res_p) n_res++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cs(input logic [19:0] a, input logic [15:0] d, input logic c);
    @(negedge clk);
    addr = a; data = d; cs = c; we = 1'b1;
    repeat (4) @(negedge clk);
    we = 1'b0;
    repeat (4) @(negedge clk);
    cs = 1'b1;
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    wr_cs(a, d, 1'b1);
  endtask

  function automatic logic [19:0] ua1();
    return bmode ? 20'hAAA : 20'h555;
  endfunction
  function automatic logic [19:0] ua2();
    return bmode ? 20'h555 : 20'h2AA;
  endfunction

  task automatic unlock();
    wr(ua1(), 16'h00AA);
    wr(ua2(), 16'h0055);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(ua1(), 16'h0080);
    unlock();
  endtask

  task automatic t_reset_state();
    chk("R14 mode after reset", mode, 0);
    chk("R14 busy after reset", busy, 0);
    chk("R14 suspended after reset", susp, 0);
    chk("R14 map after reset", $countones(map), 0);
  endtask

  task automatic t_program_word();
    int p0;
    bmode = 1'b0;
    p0 = n_prog;
    unlock();
    wr(20'h555, 16'h00A0);
    wr(20'h12345, 16'hBEEF);
    chk("R2 program pulse count", n_prog, p0 + 1);
    chk("R2 program address", last_pa, 20'h12345);
    chk("R2 program data", last_pd, 16'hBEEF);
    chk("R2 status mode while programming", mode, 2);
    chk("R2 busy while programming", busy, 1);
    wr(20'h0, 16'h00F0);
    chk("R8 reset command ignored during program", mode, 2);
    unlock();
    chk("R8 unlock ignored during program", mode, 2);
    repeat (20) @(negedge clk);
    chk("R2 busy clears after program", busy, 0);
    chk("R2 array mode after program", mode, 0);
    wr(20'h555, 16'h00A0);
    wr(20'h00100, 16'h1111);
    chk("R8 no sequence kept across program", n_prog, p0 + 1);
    chk("R7 lone A0 leaves array mode", mode, 0);
  endtask

  task automatic t_byte_mode();
    int p0;
    bmode = 1'b1;
    p0 = n_prog;
    wr(20'h555, 16'h00AA);
    wr(20'h2AA, 16'h0055);
    wr(20'hAAA, 16'h00A0);
    wr(20'h00444, 16'h0077);
    chk("R1 word addresses rejected in byte mode", n_prog, p0);
    unlock();
    wr(20'hAAA, 16'h00A0);
    wr(20'h2468A, 16'h00C3);
    chk("R1 byte mode program pulse", n_prog, p0 + 1);
    chk("R1 byte mode program address", last_pa, 20'h2468A);
    repeat (PROG_T + 5) @(negedge clk);
    chk("R1 byte program finished", busy, 0);
    bmode = 1'b0;
    p0 = n_prog;
    wr(20'hAAA, 16'h00AA);
    wr(20'h555, 16'h0055);
    wr(20'hAAA, 16'h00A0);
    wr(20'h00200, 16'h0001);
    chk("R1 byte addresses rejected in word mode", n_prog, p0);
  endtask

  task automatic t_id_and_reset();
    unlock();
    wr(20'h555, 16'h0090);
    chk("R12 identification mode", mode, 1);
    wr(20'h3F0F0, 16'h00F0);
    chk("R6 reset command returns array", mode, 0);
    unlock();
    wr(20'h555, 16'h0090);
    wr(20'h00000, 16'h0012);
    chk("R7 invalid write leaves id mode", mode, 0);
  endtask

  task automatic t_invalid();
    int p0, c0;
    p0 = n_prog; c0 = n_chip;
    unlock();
    wr(20'h555, 16'h0077);
    chk("R7 bad third data", mode, 0);
    wr(20'h2AA, 16'h0055);
    wr(20'h555, 16'h00AA);
    wr(20'h555, 16'h00A0);
    wr(20'h01000, 16'h2222);
    chk("R7 out of order cycles no program", n_prog, p0);
    erase_prefix();
    wr(20'h2AA, 16'h0010);
    chk("R7 chip erase at wrong address", n_chip, c0);
    chk("R7 busy stays low", busy, 0);
  endtask

  task automatic t_stray_suspend_resume();
    int s0, r0;
    s0 = n_susp; r0 = n_res;
    wr(20'h0, 16'h00B0);
    wr(20'h0, 16'h0030);
    chk("R11 no suspend pulse when idle", n_susp, s0);
    chk("R11 no resume pulse when idle", n_res, r0);
    chk("R11 still idle", busy, 0);
    chk("R11 not suspended", susp, 0);
  endtask

  task automatic t_chip_select();
    int p0;
    p0 = n_prog;
    wr_cs(20'h555, 16'h00AA, 1'b0);
    wr_cs(20'h2AA, 16'h0055, 1'b0);
    wr_cs(20'h555, 16'h00A0, 1'b0);
    wr_cs(20'h00300, 16'h3333, 1'b0);
    chk("R13 deselected writes ignored", n_prog, p0);
    chk("R13 busy low", busy, 0);
  endtask

  task automatic t_chip_erase();
    int c0;
    c0 = n_chip;
    erase_prefix();
    wr(20'h555, 16'h0010);
    chk("R3 chip erase pulse", n_chip, c0 + 1);
    chk("R3 all sectors selected", $countones(map), 128);
    chk("R3 status mode", mode, 2);
    repeat (ERASE_T + 10) @(negedge clk);
    chk("R3 erase completes", busy, 0);
    chk("R5 map cleared after erase", $countones(map), 0);
  endtask

  task automatic t_sector_window();
    int s0;
    s0 = n_sect;
    erase_prefix();
    wr({1'b0, 7'd5, 12'h034}, 16'h0030);
    chk("R4 window open busy", busy, 1);
    chk("R4 no pulse inside window", n_sect, s0);
    wr({1'b0, 7'd9, 12'h000}, 16'h0030);
    chk("R4 window restarted", n_sect, s0);
    repeat (WIN_T + 10) @(negedge clk);
    chk("R4 sector erase pulse after window", n_sect, s0 + 1);
    chk("R4 two sectors selected", $countones(map), 2);
    chk("R4 sector 5 selected", map[5], 1);
    chk("R4 sector 9 selected", map[9], 1);
    repeat (ERASE_T) @(negedge clk);
    chk("R4 sector erase done", busy, 0);
  endtask

  task automatic t_window_abort();
    int s0;
    s0 = n_sect;
    erase_prefix();
    wr({1'b0, 7'd2, 12'h000}, 16'h0030);
    wr(20'h0, 16'h00F0);
    chk("R5 abort clears busy", busy, 0);
    chk("R5 abort clears map", $countones(map), 0);
    chk("R5 abort array mode", mode, 0);
    repeat (WIN_T + 10) @(negedge clk);
    chk("R5 no erase after abort", n_sect, s0);
  endtask

  task automatic t_suspend();
    int p0, c0, s0, r0;
    bmode = 1'b1;
    s0 = n_susp; r0 = n_res; c0 = n_chip;
    erase_prefix();
    wr({7'd3, 13'h0010}, 16'h0030);
    repeat (WIN_T + 10) @(negedge clk);
    chk("R4 byte mode sector index", map[3], 1);
    chk("R4 byte mode single sector", $countones(map), 1);
    wr(20'h0, 16'h00B0);
    chk("R9 suspend pulse", n_susp, s0 + 1);
    chk("R9 suspended flag", susp, 1);
    chk("R9 busy low while paused", busy, 0);
    chk("R9 array mode while paused", mode, 0);
    p0 = n_prog;
    unlock();
    wr(20'hAAA, 16'h00A0);
    wr({7'd7, 13'h0002}, 16'h005A);
    chk("R10 program outside erase map", n_prog, p0 + 1);
    chk("R10 still suspended", susp, 1);
    chk("R10 status while programming", mode, 2);
    repeat (PROG_T + 10) @(negedge clk);
    chk("R10 back to paused after program", busy, 0);
    chk("R10 suspended after program", susp, 1);
    chk("R10 array after program", mode, 0);
    unlock();
    wr(20'hAAA, 16'h00A0);
    wr({7'd3, 13'h0004}, 16'h0011);
    chk("R10 program into erasing sector rejected", n_prog, p0 + 1);
    unlock();
    wr(20'hAAA, 16'h0080);
    unlock();
    wr(20'hAAA, 16'h0010);
    chk("R10 erase refused while paused", n_chip, c0);
    chk("R10 map unchanged", $countones(map), 1);
    wr(20'h0, 16'h0030);
    chk("R9 resume pulse", n_res, r0 + 1);
    chk("R9 busy after resume", busy, 1);
    chk("R9 not suspended after resume", susp, 0);
    chk("R9 status after resume", mode, 2);
    repeat (80) @(negedge clk);
    chk("R9 erase count was frozen", busy, 1);
    repeat (40) @(negedge clk);
    chk("R9 erase ends after resume", busy, 0);
    bmode = 1'b0;
  endtask

  task automatic t_hw_abort();
    unlock();
    wr(20'h555, 16'h00A0);
    wr(20'h00500, 16'h5555);
    chk("R14 program running before abort", busy, 1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R14 abort clears busy", busy, 0);
    chk("R14 abort array mode", mode, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R14 idle after release", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_program_word();
    t_byte_mode();
    t_id_and_reset();
    t_invalid();
    t_stray_suspend_resume();
    t_chip_select();
    t_chip_erase();
    t_sector_window();
    t_window_abort();
    t_suspend();
    t_hw_abort();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule